// File: doc/BRIEF.md
# SYSREF Capture and Multiframe Clock Alignment

This block keeps a free-running local multiframe counter in the fabric clock domain and emits a one-cycle boundary pulse each time the counter is at zero. An external SYSREF reference is brought into the fabric clock domain, and its rising edge realigns the counter so that the boundary pulse lands at a fixed phase relative to the reference. A capture-control register sets the multiframe length and can switch the SYSREF sampler off. The sampler is kept off while the serial link is held in reset and is switched on again afterwards.

A second register, the sync-control register, has a self-clearing request bit. Writing a one to that bit produces a single-cycle pulse toward the external clock generator, asking it to emit a SYSREF. The control flow is a three-state machine. In SR_IDLE the sampler is off. In SR_ARMED the sampler is on but no edge has been seen yet. In SR_LOCKED at least one edge has been captured since the sampler was last switched on.

The transitions are:
- SR_IDLE to SR_ARMED when the sampler is switched on.
- SR_IDLE to SR_LOCKED when the sampler is switched on and an edge is seen in the same cycle.
- SR_ARMED to SR_LOCKED on a detected edge.
- Any state to SR_IDLE whenever the sampler is off.

Top module: `lmfc_align_top`

## Requirements
- R1: After reset the capture control holds a multiframe length of 20 cycles with the sampler off. The counter is at zero, so `lmfc_pulse` is high in the first cycle. `sync_captured` and `sysref_req` are low.
- R2: The boundary pulse is one cycle wide and repeats every N cycles, where N is the programmed multiframe length. The counter wraps to zero after reaching N-1. It also wraps to zero if it is found at or above N-1 after a length change.
- R3: A write with `reg_sel`=0 loads the capture control. Bits [31:23] hold N-1, and bit 6 set switches the sampler off.
- R4: While the sampler is off, SYSREF edges have no effect on the counter phase, and `sync_captured` stays low.
- R5: While the sampler is on, SYSREF is passed through two synchronising flip-flops and its rising edge is detected. The counter is loaded with zero on the following cycle. `lmfc_pulse` is therefore high in the third cycle after SYSREF is first sampled high.
- R6: A SYSREF edge whose zero-load coincides with the natural wrap leaves the pulse phase unchanged.
- R7: `sync_captured` (state SR_LOCKED) rises together with the first realignment after the sampler is switched on. It falls once the sampler is switched off, and it stays low after re-enabling until a new edge arrives.
- R8: A write with `reg_sel`=1 and bit 30 set produces `sysref_req` high for exactly the next cycle. A write to that register with bit 30 clear produces no pulse.
- R9: Only a rising edge realigns. A SYSREF held high leaves the counter free-running at period N.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fabric clock |
| rst_n | input | 1 | Active-low synchronous reset |
| sysref_in | input | 1 | External SYSREF reference, asynchronous |
| reg_wr | input | 1 | Register write strobe |
| reg_sel | input | 1 | Register select: 0 capture control, 1 sync control |
| reg_wdata | input | 32 | Register write data |
| lmfc_pulse | output | 1 | Multiframe boundary pulse |
| sync_captured | output | 1 | At least one SYSREF edge captured since the sampler was switched on |
| sysref_req | output | 1 | One-cycle SYSREF request toward the clock generator |

## Verification
SYSREF is raised at three chosen offsets from a known boundary pulse. An edge arriving two cycles after a boundary must move the pulse to the third cycle after the rise and suppress the old-phase pulse. An edge whose load coincides with the natural wrap must leave the phase untouched, which separates correct edge-to-load latency from a one-cycle error. The same early edge is repeated with the sampler off, to tell gating apart from realignment. SYSREF is then held high across several periods, to distinguish rising-edge detection from level sensitivity.

// File: rtl/lmfc_pkg.sv
package lmfc_pkg;
    typedef enum logic [1:0] {
        SR_IDLE   = 2'd0,
        SR_ARMED  = 2'd1,
        SR_LOCKED = 2'd2
    } sr_state_e;
endpackage

// File: rtl/lmfc_sysref_sync.sv
module lmfc_sysref_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic async_in,
    output logic rise
);
    logic [STAGES-1:0] chain_q;
    logic              prev_q;

    genvar g;
    generate
        for (g = 0; g < STAGES; g++) begin : g_stage
            always_ff @(posedge clk) begin
                if (!rst_n) begin
                    chain_q[g] <= 1'b0;
                end else begin
                    chain_q[g] <= (g == 0) ? async_in : chain_q[(g == 0) ? 0 : g-1];
                end
            end
        end
    endgenerate

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            prev_q <= 1'b0;
        end else begin
            prev_q <= chain_q[STAGES-1];
        end
    end

    assign rise = chain_q[STAGES-1] & ~prev_q;
endmodule

// File: rtl/lmfc_counter.sv
module lmfc_counter #(
    parameter int CW = 9
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [CW-1:0] limit,
    input  logic          load_zero,
    output logic [CW-1:0] count,
    output logic          boundary
);
    logic [CW-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (load_zero || cnt_q >= limit) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

    assign count    = cnt_q;
    assign boundary = (cnt_q == '0);
endmodule

// File: rtl/lmfc_capture_fsm.sv
module lmfc_capture_fsm
    import lmfc_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic sampler_off,
    input  logic edge_seen,
    output logic captured
);
    sr_state_e state_q, state_d;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= SR_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            SR_IDLE: begin
                if (!sampler_off) begin
                    state_d = edge_seen ? SR_LOCKED : SR_ARMED;
                end
            end
            SR_ARMED: begin
                if (sampler_off) begin
                    state_d = SR_IDLE;
                end else if (edge_seen) begin
                    state_d = SR_LOCKED;
                end
            end
            SR_LOCKED: begin
                if (sampler_off) begin
                    state_d = SR_IDLE;
                end
            end
            default: state_d = SR_IDLE;
        endcase
    end

    always_comb begin
        captured = (state_q == SR_LOCKED);
    end
endmodule

// File: rtl/lmfc_align_top.sv
module lmfc_align_top #(
    parameter int DATA_W      = 32,
    parameter int PER_LSB     = 23,
    parameter int PER_W       = 9,
    parameter int OFF_BIT     = 6,
    parameter int REQ_BIT     = 30,
    parameter int DEF_DIV     = 20,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sysref_in,
    input  logic              reg_wr,
    input  logic              reg_sel,
    input  logic [DATA_W-1:0] reg_wdata,
    output logic              lmfc_pulse,
    output logic              sync_captured,
    output logic              sysref_req
);
    localparam logic [PER_W-1:0] RST_LIM = PER_W'(DEF_DIV - 1);

    logic [PER_W-1:0] period_lim;
    logic             sampler_off;
    logic             sysref_rise;
    logic [PER_W-1:0] lmfc_cnt;
    logic             req_q;

    // capture-control register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            period_lim  <= RST_LIM;
            sampler_off <= 1'b1;
        end else if (reg_wr && !reg_sel) begin
            period_lim  <= reg_wdata[PER_LSB +: PER_W];
            sampler_off <= reg_wdata[OFF_BIT];
        end
    end

    // sync-control request bit, self-clearing
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            req_q <= 1'b0;
        end else begin
            req_q <= reg_wr && reg_sel && reg_wdata[REQ_BIT];
        end
    end

    lmfc_sysref_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk      (clk),
        .rst_n    (rst_n),
        .async_in (sysref_in),
        .rise     (sysref_rise)
    );

    lmfc_counter #(.CW(PER_W)) u_cnt (
        .clk       (clk),
        .rst_n     (rst_n),
        .limit     (period_lim),
        .load_zero (sysref_rise && !sampler_off),
        .count     (lmfc_cnt),
        .boundary  (lmfc_pulse)
    );

    lmfc_capture_fsm u_fsm (
        .clk         (clk),
        .rst_n       (rst_n),
        .sampler_off (sampler_off),
        .edge_seen   (sysref_rise),
        .captured    (sync_captured)
    );

    assign sysref_req = req_q;
endmodule

// File: rtl/lmfc_align_chk.sv
module lmfc_align_chk #(
    parameter int DATA_W  = 32,
    parameter int PER_W   = 9,
    parameter int REQ_BIT = 30
) (
    input logic              clk,
    input logic              rst_n,
    input logic              reg_wr,
    input logic              reg_sel,
    input logic [DATA_W-1:0] reg_wdata,
    input logic              sysref_rise,
    input logic              sampler_off,
    input logic [PER_W-1:0]  period_lim,
    input logic [PER_W-1:0]  lmfc_cnt,
    input logic              lmfc_pulse,
    input logic              sync_captured,
    input logic              sysref_req
);
    assert_wrap_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (lmfc_cnt >= period_lim) |=> lmfc_pulse);

    assert_pulse_width_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (lmfc_pulse && period_lim != '0 && !(sysref_rise && !sampler_off)) |=> !lmfc_pulse);

    assert_ignore_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (sampler_off && lmfc_cnt < period_lim) |=> (lmfc_cnt == $past(lmfc_cnt) + 1'b1));

    assert_align_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (sysref_rise && !sampler_off) |=> lmfc_pulse);

    assert_cap_clear_R7: assert property (@(posedge clk) disable iff (!rst_n)
        sampler_off |=> !sync_captured);

    assert_req_fire_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_wr && reg_sel && reg_wdata[REQ_BIT]) |=> sysref_req);

    assert_req_quiet_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !(reg_wr && reg_sel && reg_wdata[REQ_BIT]) |=> !sysref_req);

    assert_rise_only_R9: assert property (@(posedge clk) disable iff (!rst_n)
        sysref_rise |=> !sysref_rise);
endmodule

bind lmfc_align_top lmfc_align_chk #(.DATA_W(DATA_W), .PER_W(PER_W), .REQ_BIT(REQ_BIT)) u_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .reg_wr        (reg_wr),
    .reg_sel       (reg_sel),
    .reg_wdata     (reg_wdata),
    .sysref_rise   (sysref_rise),
    .sampler_off   (sampler_off),
    .period_lim    (period_lim),
    .lmfc_cnt      (lmfc_cnt),
    .lmfc_pulse    (lmfc_pulse),
    .sync_captured (sync_captured),
    .sysref_req    (sysref_req)
);

// File: tb/lmfc_align_top_tb.sv
`timescale 1ns/1ps
module lmfc_align_top_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        sysref_in = 1'b0;
    logic        reg_wr = 1'b0;
    logic        reg_sel = 1'b0;
    logic [31:0] reg_wdata = '0;
    logic        lmfc_pulse;
    logic        sync_captured;
    logic        sysref_req;

    int checks = 0;
    int errors = 0;
    int cycles = 0;

    always #2.5 clk = ~clk;

    lmfc_align_top u_dut (
        .clk(clk), .rst_n(rst_n), .sysref_in(sysref_in),
        .reg_wr(reg_wr), .reg_sel(reg_sel), .reg_wdata(reg_wdata),
        .lmfc_pulse(lmfc_pulse), .sync_captured(sync_captured), .sysref_req(sysref_req)
    );

    task automatic check(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic step(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic wr_reg(input logic sel, input logic [31:0] d);
        reg_sel = sel; reg_wdata = d; reg_wr = 1'b1;
        @(negedge clk);
        reg_wr = 1'b0; reg_wdata = '0;
    endtask

    function automatic logic [31:0] cap_word(input int div, input logic off);
        return (32'(div - 1) << 23) | (32'(off) << 6);
    endfunction

    task automatic wait_pulse();
        for (int i = 0; i < 600; i++) begin
            @(negedge clk);
            if (lmfc_pulse) return;
        end
    endtask

    // assumes lmfc_pulse is high now; returns cycles to the next pulse
    task automatic measure(output int n);
        n = 0;
        for (int i = 0; i < 600; i++) begin
            @(negedge clk);
            n++;
            if (lmfc_pulse) return;
        end
    endtask

    task automatic t_reset();
        check("R1 pulse at reset", int'(lmfc_pulse), 1);
        check("R1 captured at reset", int'(sync_captured), 0);
        check("R1 req at reset", int'(sysref_req), 0);
    endtask

    task automatic t_default_period();
        int n;
        measure(n);
        check("R1 default period", n, 20);
        measure(n);
        check("R2 default period repeat", n, 20);
    endtask

    task automatic t_program_period();
        int n;
        wr_reg(1'b0, cap_word(8, 1'b1));
        wait_pulse();
        step(1);
        check("R2 pulse one cycle wide", int'(lmfc_pulse), 0);
        wait_pulse();
        measure(n);
        check("R3 programmed period 8", n, 8);
    endtask

    task automatic t_disabled_ignore();
        wait_pulse();
        sysref_in = 1'b1;
        step(3);
        check("R4 no realign when off", int'(lmfc_pulse), 0);
        step(5);
        check("R4 phase kept when off", int'(lmfc_pulse), 1);
        check("R4 captured stays low", int'(sync_captured), 0);
        sysref_in = 1'b0;
        step(4);
    endtask

    task automatic t_enable_align();
        wr_reg(1'b0, cap_word(8, 1'b0));
        step(4);
        check("R7 armed not captured", int'(sync_captured), 0);
        wait_pulse();
        step(2);
        sysref_in = 1'b1;
        step(3);
        check("R5 pulse 3 cycles after rise", int'(lmfc_pulse), 1);
        check("R7 captured after edge", int'(sync_captured), 1);
        step(3);
        check("R5 old phase gone", int'(lmfc_pulse), 0);
        step(5);
        check("R5 next pulse at new phase", int'(lmfc_pulse), 1);
        step(8);
        check("R9 held high no realign", int'(lmfc_pulse), 1);
        step(4);
        check("R9 held high mid period", int'(lmfc_pulse), 0);
        sysref_in = 1'b0;
        step(4);
    endtask

    task automatic t_aligned_edge();
        wait_pulse();
        step(5);
        sysref_in = 1'b1;
        step(2);
        check("R6 no early pulse", int'(lmfc_pulse), 0);
        step(1);
        check("R6 phase unchanged", int'(lmfc_pulse), 1);
        step(1);
        check("R6 pulse single", int'(lmfc_pulse), 0);
        step(7);
        check("R6 following period", int'(lmfc_pulse), 1);
        sysref_in = 1'b0;
        step(4);
    endtask

    task automatic t_disable_reenable();
        wr_reg(1'b0, cap_word(8, 1'b1));
        step(2);
        check("R7 captured cleared on disable", int'(sync_captured), 0);
        wr_reg(1'b0, cap_word(8, 1'b0));
        step(3);
        check("R7 re-enabled not captured", int'(sync_captured), 0);
        sysref_in = 1'b1;
        step(3);
        check("R7 captured after new edge", int'(sync_captured), 1);
        sysref_in = 1'b0;
        step(3);
    endtask

    task automatic t_sysref_request();
        wr_reg(1'b1, 32'h4000_0000);
        check("R8 request pulse", int'(sysref_req), 1);
        step(1);
        check("R8 request self clears", int'(sysref_req), 0);
        wr_reg(1'b1, 32'h2000_0000);
        check("R8 no request when bit clear", int'(sysref_req), 0);
        step(1);
        check("R8 still no request", int'(sysref_req), 0);
    endtask

    initial begin
        step(3);
        rst_n = 1'b1;
        t_reset();
        t_default_period();
        t_program_period();
        t_disabled_ignore();
        t_enable_align();
        t_aligned_edge();
        t_disable_reenable();
        t_sysref_request();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        forever begin
            @(posedge clk);
            cycles++;
            if (cycles > 20000) begin
                checks++;
                errors++;
                $display("FAIL watchdog: actual %0d expected %0d", cycles, 20000);
                $display("Simulation finished: %0d checks, %0d errors", checks, errors);
                $finish;
            end
        end
    end
endmodule